// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is a small unsigned arithmetic coprocessor for an 8-bit core. Software selects one of four operations: a narrow multiply (16-bit by 8-bit), a wide multiply (24-bit by 16-bit), a narrow divide (16-bit by 8-bit) and a wide divide (24-bit by 16-bit). It places the operands on the inputs and pulses a start strobe. The operands are sampled on the accepting clock edge. The unit then stays busy for a fixed number of cycles set by the operation, and raises a one-cycle done pulse when the result is ready.

Multiplication is shift-and-add and retires several multiplier bits per cycle. Division is restoring division and resolves several quotient bits per cycle through a chain of compare-subtract stages. The number of bits per cycle and the latency of each operation are parameters. Each latency is checked at elaboration against the number of steps the engine needs. Results stay on the outputs until the next accepted start.

Top module: `muldiv_top`

## Requirements
- R1: After reset, busy, done and div_zero are low and product, quotient and remainder read zero.
- R2: A start seen while busy is low is accepted, and busy is high from the next cycle for exactly the latency of the operation. The op_sel codes and latencies are: 2'b00 narrow multiply, 5 cycles; 2'b01 wide multiply, 12 cycles; 2'b10 narrow divide, 8 cycles; 2'b11 wide divide, 12 cycles.
- R3: done is high for exactly the one cycle after the last busy cycle, and the results are valid in that cycle.
- R4: Narrow multiply gives product = opa[15:0] * opb[7:0], zero-extended to 40 bits. opa[23:16] and opb[15:8] have no effect.
- R5: Wide multiply gives the full 40-bit product opa * opb.
- R6: Narrow divide gives quotient = opa[15:0] / opb[7:0] in quotient[15:0] with quotient[23:16] zero, and remainder = opa[15:0] mod opb[7:0] in remainder[7:0] with remainder[15:8] zero. opa[23:16] and opb[15:8] have no effect.
- R7: Wide divide gives quotient = opa / opb (24 bits) and remainder = opa mod opb (16 bits).
- R8: A divide by zero (narrow mode tests only opb[7:0]) sets div_zero at done. The quotient is all ones across the dividend width: 24'h00FFFF narrow, 24'hFFFFFF wide. The remainder is the dividend's low 16 bits. div_zero is low after every other operation.
- R9: A start pulse while busy is ignored: it changes neither the running latency nor the results.
- R10: Operands are captured at acceptance, so later changes on opa, opb and op_sel have no effect. Outputs hold until the next accepted start. A divide leaves product unchanged, and a multiply leaves quotient and remainder unchanged.
- R11: A start in the done cycle is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only while idle |
| op_sel | input | 2 | Operation code (see R2) |
| opa | input | 24 | Multiplicand or dividend |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| product | output | 40 | Multiply result |
| quotient | output | 24 | Divide quotient |
| remainder | output | 16 | Divide remainder |
| div_zero | output | 1 | Last divide had a zero divisor |

## Verification
The assertions compare results against operands that the checker itself latches when a start is accepted. They therefore assume that start, op_sel, opa and opb are free of X on every clock edge, and that starts raised while busy are never meant to replace the running operation. The bench drives every input from the falling edge so that inputs always hold a defined value. After acceptance it deliberately scrambles the operand and op_sel inputs, so capture is exercised. Its mid-operation start pulses carry different operands, so an accidental restart would show up as a wrong latency or a wrong result.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      MD_MUL_N = 2'b00,
      MD_MUL_W = 2'b01,
      MD_DIV_N = 2'b10,
      MD_DIV_W = 2'b11
   } md_op_e;

   function automatic logic md_is_div(input md_op_e o);
      logic [1:0] v;
      v = o;
      return v[1];
   endfunction

   function automatic logic md_is_wide(input md_op_e o);
      logic [1:0] v;
      v = o;
      return v[0];
   endfunction

   function automatic int md_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
   import muldiv_pkg::*;
#(
   parameter int LAT_MUL_N = 5,
   parameter int LAT_MUL_W = 12,
   parameter int LAT_DIV_N = 8,
   parameter int LAT_DIV_W = 12,
   localparam int LAT_MAX  = md_max4(LAT_MUL_N, LAT_MUL_W, LAT_DIV_N, LAT_DIV_W),
   localparam int CNT_W    = $clog2(LAT_MAX + 1)
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  md_op_e op,
   output logic   accept,
   output logic   busy,
   output logic   done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lat_sel;
   logic             busy_q;
   logic             done_q;

   always_comb begin
      unique case (op)
         MD_MUL_N: lat_sel = CNT_W'(LAT_MUL_N);
         MD_MUL_W: lat_sel = CNT_W'(LAT_MUL_W);
         MD_DIV_N: lat_sel = CNT_W'(LAT_DIV_N);
         default:  lat_sel = CNT_W'(LAT_DIV_W);
      endcase
   end

   assign accept = start & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy_q && (cnt_q == CNT_W'(1));
         if (accept) begin
            cnt_q  <= lat_sel;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
   parameter int AW  = 24,
   parameter int BW  = 16,
   parameter int BPC = 2,
   localparam int PW = AW + BW,
   localparam int SW = $clog2(BW / BPC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step_en,
   input  logic [AW-1:0] mcand,
   input  logic [BW-1:0] mplier,
   input  logic [SW-1:0] nsteps,
   output logic [PW-1:0] product
);

   logic [PW-1:0] acc_q;
   logic [PW-1:0] mcand_q;
   logic [BW-1:0] mplier_q;
   logic [SW-1:0] left_q;
   logic [PW-1:0] term [BPC];
   logic [PW-1:0] add_sum;

   for (genvar g = 0; g < BPC; g++) begin : g_term
      assign term[g] = mplier_q[g] ? (mcand_q << g) : '0;
   end

   always_comb begin
      add_sum = '0;
      for (int j = 0; j < BPC; j++) add_sum = add_sum + term[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
         left_q   <= '0;
      end else if (load) begin
         acc_q    <= '0;
         mcand_q  <= PW'(mcand);
         mplier_q <= mplier;
         left_q   <= nsteps;
      end else if (step_en && (left_q != '0)) begin
         acc_q    <= acc_q + add_sum;
         mcand_q  <= mcand_q << BPC;
         mplier_q <= mplier_q >> BPC;
         left_q   <= left_q - SW'(1);
      end
   end

   assign product = acc_q;

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
   parameter int AW  = 24,
   parameter int BW  = 16,
   parameter int BPC = 2,
   localparam int SW = $clog2(AW / BPC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step_en,
   input  logic [AW-1:0] dividend,
   input  logic [BW-1:0] divisor,
   input  logic [SW-1:0] nsteps,
   output logic [AW-1:0] quotient,
   output logic [BW-1:0] remainder
);

   logic [AW-1:0] quo_q;
   logic [BW-1:0] rem_q;
   logic [BW-1:0] dvs_q;
   logic [SW-1:0] left_q;
   logic [AW-1:0] q_st [BPC+1];
   logic [BW-1:0] r_st [BPC+1];

   assign q_st[0] = quo_q;
   assign r_st[0] = rem_q;

   for (genvar g = 0; g < BPC; g++) begin : g_stage
      logic [BW:0] trial;
      logic        fits;
      assign trial      = {r_st[g], q_st[g][AW-1]};
      assign fits       = trial >= {1'b0, dvs_q};
      assign r_st[g+1]  = fits ? (trial[BW-1:0] - dvs_q) : trial[BW-1:0];
      assign q_st[g+1]  = {q_st[g][AW-2:0], fits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         left_q <= '0;
      end else if (load) begin
         quo_q  <= dividend;
         rem_q  <= '0;
         dvs_q  <= divisor;
         left_q <= nsteps;
      end else if (step_en && (left_q != '0)) begin
         quo_q  <= q_st[BPC];
         rem_q  <= r_st[BPC];
         left_q <= left_q - SW'(1);
      end
   end

   assign quotient  = quo_q;
   assign remainder = rem_q;

endmodule

// File: rtl/muldiv_top.sv
module muldiv_top
   import muldiv_pkg::*;
#(
   parameter int A_W       = 24,
   parameter int A_N       = 16,
   parameter int B_W       = 16,
   parameter int B_N       = 8,
   parameter int MUL_BPC   = 2,
   parameter int DIV_BPC   = 2,
   parameter int LAT_MUL_N = 5,
   parameter int LAT_MUL_W = 12,
   parameter int LAT_DIV_N = 8,
   parameter int LAT_DIV_W = 12,
   localparam int PW       = A_W + B_W,
   localparam int MSW      = $clog2(B_W / MUL_BPC + 1),
   localparam int DSW      = $clog2(A_W / DIV_BPC + 1),
   localparam int PAD      = A_W - A_N
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [1:0]     op_sel,
   input  logic [A_W-1:0] opa,
   input  logic [B_W-1:0] opb,
   output logic           busy,
   output logic           done,
   output logic [PW-1:0]  product,
   output logic [A_W-1:0] quotient,
   output logic [B_W-1:0] remainder,
   output logic           div_zero
);

   if (A_N > A_W || B_N > B_W) begin : g_bad_width
      $error("narrow operand wider than wide operand");
   end
   if ((A_N % DIV_BPC) != 0 || (A_W % DIV_BPC) != 0) begin : g_bad_dbpc
      $error("dividend widths must be multiples of DIV_BPC");
   end
   if ((B_N % MUL_BPC) != 0 || (B_W % MUL_BPC) != 0) begin : g_bad_mbpc
      $error("multiplier widths must be multiples of MUL_BPC");
   end
   if (B_N / MUL_BPC > LAT_MUL_N || B_W / MUL_BPC > LAT_MUL_W) begin : g_bad_mlat
      $error("multiply latency shorter than step count");
   end
   if (A_N / DIV_BPC > LAT_DIV_N || A_W / DIV_BPC > LAT_DIV_W) begin : g_bad_dlat
      $error("divide latency shorter than step count");
   end
   if (LAT_MUL_N < 1 || LAT_MUL_W < 1 || LAT_DIV_N < 1 || LAT_DIV_W < 1) begin : g_bad_lat
      $error("latencies must be at least one cycle");
   end

   md_op_e          op;
   logic            accept;
   logic            is_div;
   logic            is_wide;
   logic [A_W-1:0]  a_sel;
   logic [B_W-1:0]  b_sel;
   logic [A_W-1:0]  dvd_aligned;
   logic [MSW-1:0]  mul_steps;
   logic [DSW-1:0]  div_steps;
   logic            dz_q;

   assign op      = md_op_e'(op_sel);
   assign is_div  = md_is_div(op);
   assign is_wide = md_is_wide(op);

   assign a_sel = is_wide ? opa : A_W'(opa[A_N-1:0]);
   assign b_sel = is_wide ? opb : B_W'(opb[B_N-1:0]);

   // narrow dividend is left-aligned so its top bit enters the divider first
   assign dvd_aligned = is_wide ? opa : (A_W'(opa[A_N-1:0]) << PAD);

   assign mul_steps = is_wide ? MSW'(B_W / MUL_BPC) : MSW'(B_N / MUL_BPC);
   assign div_steps = is_wide ? DSW'(A_W / DIV_BPC) : DSW'(A_N / DIV_BPC);

   muldiv_seq #(
      .LAT_MUL_N (LAT_MUL_N),
      .LAT_MUL_W (LAT_MUL_W),
      .LAT_DIV_N (LAT_DIV_N),
      .LAT_DIV_W (LAT_DIV_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .op     (op),
      .accept (accept),
      .busy   (busy),
      .done   (done)
   );

   muldiv_mul #(
      .AW  (A_W),
      .BW  (B_W),
      .BPC (MUL_BPC)
   ) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept & ~is_div),
      .step_en (busy),
      .mcand   (a_sel),
      .mplier  (b_sel),
      .nsteps  (mul_steps),
      .product (product)
   );

   muldiv_div #(
      .AW  (A_W),
      .BW  (B_W),
      .BPC (DIV_BPC)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept & is_div),
      .step_en   (busy),
      .dividend  (dvd_aligned),
      .divisor   (b_sel),
      .nsteps    (div_steps),
      .quotient  (quotient),
      .remainder (remainder)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dz_q <= 1'b0;
      else if (accept) dz_q <= is_div && (b_sel == '0);
   end

   assign div_zero = dz_q;

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
   parameter int A_W       = 24,
   parameter int A_N       = 16,
   parameter int B_W       = 16,
   parameter int B_N       = 8,
   parameter int LAT_MUL_N = 5,
   parameter int LAT_MUL_W = 12,
   parameter int LAT_DIV_N = 8,
   parameter int LAT_DIV_W = 12,
   localparam int PW       = A_W + B_W,
   localparam int LW       = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [1:0]     op_sel,
   input logic [A_W-1:0] opa,
   input logic [B_W-1:0] opb,
   input logic           busy,
   input logic           done,
   input logic [PW-1:0]  product,
   input logic [A_W-1:0] quotient,
   input logic [B_W-1:0] remainder,
   input logic           div_zero
);

   logic [1:0]     cap_op;
   logic [A_W-1:0] cap_a;
   logic [B_W-1:0] cap_b;
   logic [LW-1:0]  busy_len;
   logic [LW-1:0]  exp_lat;
   logic [A_W-1:0] ref_a;
   logic [B_W-1:0] ref_b;
   logic [A_W-1:0] q_ones;
   logic [127:0]   ref_prod;
   logic [127:0]   recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_op   <= '0;
         cap_a    <= '0;
         cap_b    <= '0;
         busy_len <= '0;
      end else if (start && !busy) begin
         cap_op   <= op_sel;
         cap_a    <= opa;
         cap_b    <= opb;
         busy_len <= '0;
      end else if (busy) begin
         busy_len <= busy_len + LW'(1);
      end
   end

   always_comb begin
      case (cap_op)
         2'b00:   exp_lat = LW'(LAT_MUL_N);
         2'b01:   exp_lat = LW'(LAT_MUL_W);
         2'b10:   exp_lat = LW'(LAT_DIV_N);
         default: exp_lat = LW'(LAT_DIV_W);
      endcase
      ref_a    = cap_op[0] ? cap_a : A_W'(cap_a[A_N-1:0]);
      ref_b    = cap_op[0] ? cap_b : B_W'(cap_b[B_N-1:0]);
      q_ones   = cap_op[0] ? '1 : A_W'({A_N{1'b1}});
      ref_prod = 128'(ref_a) * 128'(ref_b);
      recon    = 128'(quotient) * 128'(ref_b) + 128'(remainder);
   end

   assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_len == exp_lat);
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_mul_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_op[1]) |-> product == ref_prod[PW-1:0]);
   assert_div_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_op[1] && ref_b != '0) |->
         (recon == 128'(ref_a) && remainder < ref_b && !div_zero));
   assert_dz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_op[1] && ref_b == '0) |->
         (div_zero && quotient == q_ones && remainder == ref_a[B_W-1:0]));
   assert_nodz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_op[1]) |-> !div_zero);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |->
         ($stable(product) && $stable(quotient) && $stable(remainder) && $stable(div_zero)));

endmodule

bind muldiv_top muldiv_chk #(
   .A_W       (A_W),
   .A_N       (A_N),
   .B_W       (B_W),
   .B_N       (B_N),
   .LAT_MUL_N (LAT_MUL_N),
   .LAT_MUL_W (LAT_MUL_W),
   .LAT_DIV_N (LAT_DIV_N),
   .LAT_DIV_W (LAT_DIV_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_sel    (op_sel),
   .opa       (opa),
   .opb       (opb),
   .busy      (busy),
   .done      (done),
   .product   (product),
   .quotient  (quotient),
   .remainder (remainder),
   .div_zero  (div_zero)
);

// File: tb/muldiv_top_tb_top.sv
module muldiv_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [23:0] opa = '0;
   logic [15:0] opb = '0;
   logic        busy;
   logic        done;
   logic [39:0] product;
   logic [23:0] quotient;
   logic [15:0] remainder;
   logic        div_zero;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [39:0] r_prod;
   logic [23:0] r_quo;
   logic [15:0] r_rem;
   logic        r_dz;
   int          r_cyc;

   always #10 clk = ~clk;

   muldiv_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op_sel    (op_sel),
      .opa       (opa),
      .opb       (opb),
      .busy      (busy),
      .done      (done),
      .product   (product),
      .quotient  (quotient),
      .remainder (remainder),
      .div_zero  (div_zero)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lat_of(input logic [1:0] op);
      case (op)
         2'b00:   return 5;
         2'b01:   return 12;
         2'b10:   return 8;
         default: return 12;
      endcase
   endfunction

   // call at a falling edge; returns at the falling edge where done is seen
   task automatic run_op(input logic [1:0] op, input logic [23:0] a, input logic [15:0] b,
                         input bit poke);
      start = 1'b1; op_sel = op; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0; op_sel = ~op; opa = ~a; opb = ~b;   // R10: scramble after capture
      r_cyc = 0;
      while (busy && r_cyc < 100) begin
         r_cyc++;
         start = poke && (r_cyc == 2);
         @(negedge clk);
      end
      start = 1'b0;
      check(r_cyc == lat_of(op), "R2 busy length", 64'(r_cyc), 64'(lat_of(op)));
      check(done === 1'b1, "R3 done at end", 64'(done), 64'd1);
      r_prod = product; r_quo = quotient; r_rem = remainder; r_dz = div_zero;
   endtask

   task automatic idle_after;
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R3 done single cycle", {62'd0, busy, done}, 64'd0);
   endtask

   task automatic do_mul(input logic [1:0] op, input logic [23:0] a, input logic [15:0] b, input string tag);
      logic [39:0] e;
      e = op[0] ? 40'(a) * 40'(b) : 40'(a[15:0]) * 40'(b[7:0]);
      run_op(op, a, b, 1'b0);
      check(r_prod == e, tag, 64'(r_prod), 64'(e));
      check(r_dz == 1'b0, "R8 no flag on multiply", 64'(r_dz), 64'd0);
      idle_after();
   endtask

   task automatic do_div(input logic [1:0] op, input logic [23:0] a, input logic [15:0] b, input string tag);
      logic [23:0] dvd, eq;
      logic [15:0] dvs, er;
      logic        ez;
      dvd = op[0] ? a : 24'(a[15:0]);
      dvs = op[0] ? b : 16'(b[7:0]);
      if (dvs == 0) begin
         eq = op[0] ? 24'hFFFFFF : 24'h00FFFF;
         er = dvd[15:0];
         ez = 1'b1;
      end else begin
         eq = dvd / 24'(dvs);
         er = 16'(dvd % 24'(dvs));
         ez = 1'b0;
      end
      run_op(op, a, b, 1'b0);
      check(r_quo == eq, {tag, " quotient"}, 64'(r_quo), 64'(eq));
      check(r_rem == er, {tag, " remainder"}, 64'(r_rem), 64'(er));
      check(r_dz == ez, {tag, " div_zero"}, 64'(r_dz), 64'(ez));
      idle_after();
   endtask

   task automatic t_reset;
      check(busy === 0 && done === 0 && div_zero === 0, "R1 flags after reset",
            {61'd0, busy, done, div_zero}, 64'd0);
      check(product === 0 && quotient === 0 && remainder === 0, "R1 results after reset",
            64'(product), 64'd0);
   endtask

   task automatic t_mul;
      do_mul(2'b00, 24'h001234, 16'h0056, "R4 narrow mul small");
      do_mul(2'b00, 24'hABFFFF, 16'h77FF, "R4 narrow mul max, upper bits ignored");
      do_mul(2'b00, 24'h000000, 16'h00FF, "R4 narrow mul zero");
      do_mul(2'b01, 24'hFFFFFF, 16'hFFFF, "R5 wide mul max");
      do_mul(2'b01, 24'h123456, 16'h9ABC, "R5 wide mul pattern");
   endtask

   task automatic t_div;
      do_div(2'b10, 24'h00FFFF, 16'h0007, "R6 narrow div");
      do_div(2'b10, 24'hEE1234, 16'hAB01, "R6 narrow div by one, upper ignored");
      do_div(2'b10, 24'h000005, 16'h00FF, "R6 narrow div small dividend");
      do_div(2'b11, 24'hFFFFFF, 16'hFFFF, "R7 wide div max");
      do_div(2'b11, 24'h123456, 16'h0003, "R7 wide div pattern");
      do_div(2'b11, 24'h00ABCD, 16'hABCE, "R7 wide div quotient zero");
   endtask

   task automatic t_divzero;
      do_div(2'b10, 24'h00BEEF, 16'h0000, "R8 narrow div by zero");
      do_div(2'b11, 24'hC0FFEE, 16'h0000, "R8 wide div by zero");
      do_div(2'b10, 24'h001234, 16'h5500, "R8 narrow zero with upper divisor bits");
      do_mul(2'b00, 24'h000003, 16'h0003, "R8 flag cleared by multiply");
   endtask

   task automatic t_busy_start;
      run_op(2'b11, 24'h0F0000, 16'h0010, 1'b1);
      check(r_quo == 24'h00F000 && r_rem == 16'h0000, "R9 start while busy ignored",
            64'(r_quo), 64'h00F000);
      idle_after();
      run_op(2'b00, 24'h000100, 16'h0002, 1'b1);
      check(r_prod == 40'h200, "R9 ignored start on short op", 64'(r_prod), 64'h200);
      idle_after();
   endtask

   task automatic t_hold;
      logic [39:0] p;
      do_mul(2'b01, 24'h00FF00, 16'h0101, "R10 setup mul");
      p = r_prod;
      do_div(2'b11, 24'h000064, 16'h000A, "R10 setup div");
      check(product == p, "R10 product kept across divide", 64'(product), 64'(p));
      do_mul(2'b00, 24'h000002, 16'h0002, "R10 setup mul 2");
      check(quotient == 24'd10 && remainder == 16'd0, "R10 quotient kept across multiply",
            64'(quotient), 64'd10);
      repeat (5) @(negedge clk);
      check(product == 40'd4 && quotient == 24'd10, "R10 results hold while idle",
            64'(product), 64'd4);
   endtask

   task automatic t_back2back;
      run_op(2'b00, 24'h000010, 16'h0010, 1'b0);
      check(r_prod == 40'h100, "R11 first op", 64'(r_prod), 64'h100);
      run_op(2'b10, 24'h000064, 16'h0007, 1'b0);
      check(r_quo == 24'd14 && r_rem == 16'd2, "R11 second op started in done cycle",
            64'(r_quo), 64'd14);
      idle_after();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mul();
      t_div();
      t_divzero();
      t_busy_start();
      t_hold();
      t_back2back();
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog expired", 64'd0, 64'd1);
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule